// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move data between its own data port and a local packet buffer RAM without addressing that RAM directly. The host writes a 16-bit start address and a 16-bit byte count into byte-wide registers. It then writes a command that opens a read or a write transfer, or that cancels one. Each accepted data-port beat moves one byte, or one 16-bit word when word mode is configured. On each beat the engine moves its current address forward and lowers its remaining count. When the count reaches zero, the engine raises a completion flag and returns to idle.

In read mode the engine fetches the next item from RAM before the host asks for it. The current address that the host reads back therefore already points past the item waiting at the port. The host data port is two streams. The write stream (host to RAM) uses `wr_valid`/`wr_ready`. The read stream (RAM to host) uses `rd_valid`/`rd_ready`. A beat happens only on a cycle where valid and ready are both high. `rd_valid` and `rd_data` hold steady until the host takes the item. `wr_ready` does not depend on `wr_valid`. A command register write takes precedence over a data beat in the same cycle: both ready and valid are forced low on that cycle. The buffer RAM port is synchronous, and read data returns one cycle after the request.

Top module: `rdma_port_top`

## Requirements
- R1: After reset the current address and remaining count read back as 0, the completion flag is clear, and `rd_valid`, `wr_ready` and `mem_req` are low.
- R2: In a write to offset 0x0, bits 7:6 select the register page and bits 5:3 select the operation. Code 1 opens a read and code 2 opens a write. Codes 4 to 7 abort. Codes 0 and 3 leave any running transfer unchanged. Offset 0x0 reads back the page and the last code written.
- R3: On page 0, writes to offsets 0x8/0x9 set the start address (low/high byte) and writes to 0xA/0xB set the byte count. On page 0, reads of 0x8/0x9 return the live current address and reads of 0xA/0xB return the remaining count. On any other page these reads return 0.
- R4: A read transfer delivers RAM bytes in rising address order. In byte mode `rd_data` = {8'h00, mem[a]}. In word mode `rd_data` = {mem[a+1], mem[a]}.
- R5: While a read item waits at the port, the current address reads back as that item's address plus its size, because the engine has already fetched ahead.
- R6: A write beat stores `wr_data[7:0]` at the current address. In word mode it also stores `wr_data[15:8]` at the next address. Nothing is written outside the programmed range.
- R7: Word mode is bit 0 of offset 0xE (page 0) and is latched at the start. Each item moves 2 bytes in word mode and 1 byte otherwise, and the address and count change by the size of the item. When 1 byte remains in word mode, the last item is a single byte in the low lane.
- R8: When the count reaches zero, bit 6 of offset 0x7 and the `done` pin are set and the engine goes idle. Writing a 1 to bit 6 of 0x7 on page 0 clears them. Nothing else clears them.
- R9: Opening a read or write with a count of 0 sets the completion flag at once and moves no data.
- R10: An abort command drops `rd_valid` and `wr_ready` from the next cycle onward. It freezes the address and count and does not set the completion flag.
- R11: While idle, the engine ignores data-port traffic: `wr_ready` stays low, nothing is written to RAM, and the address and count are unchanged.
- R12: A waiting read item keeps `rd_valid` high and `rd_data` stable until it is taken. During a write transfer `wr_ready` stays high whether or not `wr_valid` is asserted.
- R13: Rewriting the start registers during a transfer does not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| wr_valid | input | 1 | Host write item valid |
| wr_ready | output | 1 | Engine accepts a write item |
| wr_data | input | 16 | Host write item |
| rd_valid | output | 1 | Read item available |
| rd_ready | input | 1 | Host takes the read item |
| rd_data | output | 16 | Read item |
| mem_req | output | 1 | RAM access request |
| mem_we | output | 1 | RAM access is a write |
| mem_be | output | 2 | RAM byte lane enables |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after request |
| done | output | 1 | Completion flag |

## Verification
A table of transfers runs reads and writes in both byte and word mode. The table pairs even and odd start addresses with even and odd counts, so a lane or stepping error shows up as a wrong byte, or a stray byte just past the range. The read cases hold the port back for several cycles before taking the item. This separates a correct held item from one that is overwritten, and it exposes the prefetch offset in the address readback. Directed cases cover an abort in the middle of a read, traffic while idle, a zero-count start, no-op command codes, a start-register rewrite during a write, and page-dependent readback.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [3:0] OFS_CMD    = 4'h0;
  localparam logic [3:0] OFS_STAT   = 4'h7;
  localparam logic [3:0] OFS_ADR_LO = 4'h8;
  localparam logic [3:0] OFS_ADR_HI = 4'h9;
  localparam logic [3:0] OFS_CNT_LO = 4'hA;
  localparam logic [3:0] OFS_CNT_HI = 4'hB;
  localparam logic [3:0] OFS_CFG    = 4'hE;

  localparam logic [2:0] OP_READ  = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;

  localparam int DONE_BIT = 6;
  localparam int WORD_BIT = 0;
  localparam int LANES    = 2;
  localparam int LANE_W   = 8;
  localparam int DATA_W   = LANES * LANE_W;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_READ  = 2'd1,
    XF_WRITE = 2'd2
  } xf_mode_e;
endpackage

// File: rtl/rdma_regfile.sv
module rdma_regfile
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic              done_set,
  output logic              cmd_hit,
  output logic              cmd_load,
  output xf_mode_e          cmd_mode,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CNT_W-1:0]  start_cnt,
  output logic              word_mode,
  output logic              done
);
  localparam int AHI_W = ADDR_W - 8;
  localparam int CHI_W = CNT_W - 8;

  logic [1:0] page;
  logic [2:0] op_rb;
  logic       page0;
  logic       cmd_wr;
  logic [2:0] op;
  logic       op_rd, op_wrt, op_kill;
  logic       cnt_zero;
  logic       zero_start;
  logic       stat_clr;

  assign page0      = (page == 2'b00);
  assign cmd_wr     = reg_we && (reg_addr == OFS_CMD);
  assign op         = reg_wdata[5:3];
  assign op_rd      = (op == OP_READ);
  assign op_wrt     = (op == OP_WRITE);
  assign op_kill    = op[2];
  assign cnt_zero   = (start_cnt == '0);
  assign cmd_load   = cmd_wr && (op_rd || op_wrt);
  assign cmd_hit    = cmd_wr && (op_rd || op_wrt || op_kill);
  assign zero_start = cmd_load && cnt_zero;
  assign stat_clr   = reg_we && page0 && (reg_addr == OFS_STAT) && reg_wdata[DONE_BIT];

  always_comb begin
    cmd_mode = XF_IDLE;
    if (cmd_load && !cnt_zero) begin
      cmd_mode = op_rd ? XF_READ : XF_WRITE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page       <= '0;
      op_rb      <= '0;
      start_addr <= '0;
      start_cnt  <= '0;
      word_mode  <= 1'b0;
      done       <= 1'b0;
    end else begin
      if (cmd_wr) begin
        page  <= reg_wdata[7:6];
        op_rb <= op;
      end
      if (reg_we && page0) begin
        case (reg_addr)
          OFS_ADR_LO: start_addr[7:0]        <= reg_wdata;
          OFS_ADR_HI: start_addr[ADDR_W-1:8] <= reg_wdata[AHI_W-1:0];
          OFS_CNT_LO: start_cnt[7:0]         <= reg_wdata;
          OFS_CNT_HI: start_cnt[CNT_W-1:8]   <= reg_wdata[CHI_W-1:0];
          OFS_CFG:    word_mode              <= reg_wdata[WORD_BIT];
          default: ;
        endcase
      end
      if (done_set || zero_start) begin
        done <= 1'b1;
      end else if (stat_clr) begin
        done <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CMD:    reg_rdata = {page, op_rb, 3'b000};
      OFS_STAT:   if (page0) reg_rdata[DONE_BIT] = done;
      OFS_ADR_LO: if (page0) reg_rdata = cur_addr[7:0];
      OFS_ADR_HI: if (page0) reg_rdata = 8'(cur_addr >> 8);
      OFS_CNT_LO: if (page0) reg_rdata = cur_cnt[7:0];
      OFS_CNT_HI: if (page0) reg_rdata = 8'(cur_cnt >> 8);
      OFS_CFG:    if (page0) reg_rdata[WORD_BIT] = word_mode;
      default: ;
    endcase
  end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hit,
  input  logic              cmd_load,
  input  xf_mode_e          cmd_mode,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic              word_mode,
  input  logic              wr_valid,
  input  logic              rd_fire,
  input  logic              slot_free,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              wr_ready,
  output logic              wr_fire,
  output logic              fetch_issue,
  output logic              wide_now,
  output logic              done_set
);
  xf_mode_e          mode;
  logic              xfer_word;
  logic [CNT_W-1:0]  step_c;
  logic [ADDR_W-1:0] step_a;
  logic              item_done;
  logic              last;

  assign wide_now    = xfer_word && (cur_cnt > CNT_W'(1));
  assign step_c      = wide_now ? CNT_W'(2) : CNT_W'(1);
  assign step_a      = wide_now ? ADDR_W'(2) : ADDR_W'(1);
  assign wr_ready    = (mode == XF_WRITE) && !cmd_hit;
  assign wr_fire     = wr_ready && wr_valid;
  assign fetch_issue = (mode == XF_READ) && !cmd_hit && slot_free && (cur_cnt != '0);
  assign item_done   = wr_fire || ((mode == XF_READ) && rd_fire);
  assign last        = (cur_cnt == step_c);
  assign done_set    = item_done && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= XF_IDLE;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      xfer_word <= 1'b0;
    end else if (cmd_hit) begin
      mode <= cmd_mode;
      if (cmd_load) begin
        cur_addr  <= start_addr;
        cur_cnt   <= start_cnt;
        xfer_word <= word_mode;
      end
    end else begin
      if (wr_fire || fetch_issue) begin
        cur_addr <= cur_addr + step_a;
      end
      if (item_done) begin
        cur_cnt <= cur_cnt - step_c;
        if (last) begin
          mode <= XF_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/rdma_fetch_buf.sv
module rdma_fetch_buf
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_issue,
  input  logic              fetch_wide,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_fire,
  output logic              slot_free
);
  logic              inflight;
  logic              wide_q;
  logic              held;
  logic [DATA_W-1:0] cap_data;

  assign rd_valid  = held && !flush;
  assign rd_fire   = rd_valid && rd_ready;
  assign slot_free = !inflight && !held;

  for (genvar g = 0; g < LANES; g++) begin : g_cap
    logic lane_on;
    assign lane_on = (g == 0) ? 1'b1 : wide_q;
    assign cap_data[g*LANE_W +: LANE_W] = lane_on ? mem_rdata[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= 1'b0;
      wide_q   <= 1'b0;
      held     <= 1'b0;
      rd_data  <= '0;
    end else if (flush) begin
      inflight <= 1'b0;
      held     <= 1'b0;
    end else begin
      inflight <= fetch_issue;
      if (fetch_issue) begin
        wide_q <= fetch_wide;
      end
      if (inflight) begin
        held    <= 1'b1;
        rd_data <= cap_data;
      end else if (rd_fire) begin
        held <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdma_port_top.sv
module rdma_port_top
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done
);
  logic              cmd_hit, cmd_load;
  xf_mode_e          cmd_mode;
  logic [ADDR_W-1:0] start_addr, cur_addr;
  logic [CNT_W-1:0]  start_cnt, cur_cnt;
  logic              word_mode;
  logic              done_set;
  logic              wr_fire, fetch_issue, wide_now;
  logic              rd_fire, slot_free;

  rdma_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cur_addr   (cur_addr),
    .cur_cnt    (cur_cnt),
    .done_set   (done_set),
    .cmd_hit    (cmd_hit),
    .cmd_load   (cmd_load),
    .cmd_mode   (cmd_mode),
    .start_addr (start_addr),
    .start_cnt  (start_cnt),
    .word_mode  (word_mode),
    .done       (done)
  );

  rdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_hit     (cmd_hit),
    .cmd_load    (cmd_load),
    .cmd_mode    (cmd_mode),
    .start_addr  (start_addr),
    .start_cnt   (start_cnt),
    .word_mode   (word_mode),
    .wr_valid    (wr_valid),
    .rd_fire     (rd_fire),
    .slot_free   (slot_free),
    .cur_addr    (cur_addr),
    .cur_cnt     (cur_cnt),
    .wr_ready    (wr_ready),
    .wr_fire     (wr_fire),
    .fetch_issue (fetch_issue),
    .wide_now    (wide_now),
    .done_set    (done_set)
  );

  rdma_fetch_buf u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (cmd_hit),
    .fetch_issue (fetch_issue),
    .fetch_wide  (wide_now),
    .mem_rdata   (mem_rdata),
    .rd_ready    (rd_ready),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_fire     (rd_fire),
    .slot_free   (slot_free)
  );

  assign mem_req  = fetch_issue || wr_fire;
  assign mem_we   = wr_fire;
  assign mem_addr = cur_addr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    assign lane_on = (g == 0) ? 1'b1 : wide_now;
    assign mem_be[g] = lane_on;
    assign mem_wdata[g*LANE_W +: LANE_W] = lane_on ? wr_data[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/rdma_chk.sv
module rdma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic        abort_bit,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [15:0] rd_data,
  input logic        mem_req,
  input logic        mem_we,
  input logic        done
);
  logic cmd_cyc, stat_cyc;
  assign cmd_cyc  = reg_we && (reg_addr == 4'h0);
  assign stat_cyc = reg_we && (reg_addr == 4'h7);

  // R6
  wr_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (wr_valid && wr_ready));

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cyc && abort_bit) |=> (!rd_valid && !wr_ready));

  // R12
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (cmd_cyc || (rd_valid && $stable(rd_data))));

  // R12
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready));

  // R5
  one_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !(mem_req && !mem_we));

  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past((rd_valid && rd_ready) || (wr_valid && wr_ready) || cmd_cyc));

  // R8
  done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stat_cyc) |=> done);
endmodule

bind rdma_port_top rdma_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .abort_bit (reg_wdata[5]),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .done      (done)
);

// File: tb/tb_rdma_port_top.sv
`timescale 1ns/1ps
module tb_rdma_port_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        wr_valid, wr_ready;
  logic [15:0] wr_data;
  logic        rd_valid, rd_ready;
  logic [15:0] rd_data;
  logic        mem_req, mem_we;
  logic [1:0]  mem_be;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        done;

  always #2 clk = ~clk;

  rdma_port_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done)
  );

  int tests = 0;
  int fails = 0;
  bit ended = 1'b0;

  logic [7:0] tbmem [0:1023];
  wire  [9:0] ia  = mem_addr[9:0];
  wire  [9:0] ia1 = mem_addr[9:0] + 10'd1;

  function automatic logic [7:0] initv(int i);
    return 8'(((i % 1024) * 7) + 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) tbmem[i] <= initv(i);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        if (mem_be[0]) tbmem[ia]  <= mem_wdata[7:0];
        if (mem_be[1]) tbmem[ia1] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= {tbmem[ia1], tbmem[ia]};
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_rd(input string tag);
    int t;
    t = 0;
    while (!rd_valid && t < 1000) begin
      @(negedge clk);
      t++;
    end
    if (!rd_valid) chk(tag, 32'd0, 32'd1);
  endtask

  task automatic pop(input string tag, output logic [15:0] d);
    @(negedge clk);
    wait_rd(tag);
    d = rd_data;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic push(input string tag, input logic [15:0] d);
    int t;
    t = 0;
    @(negedge clk);
    while (!wr_ready && t < 1000) begin
      @(negedge clk);
      t++;
    end
    if (!wr_ready) chk(tag, 32'd0, 32'd1);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  typedef struct packed {
    logic        is_wr;
    logic        word;
    logic [15:0] start;
    logic [15:0] cnt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 16'h0010, 16'd5},
    '{1'b0, 1'b1, 16'h0040, 16'd8},
    '{1'b0, 1'b1, 16'h0081, 16'd5},
    '{1'b1, 1'b0, 16'h0100, 16'd4},
    '{1'b1, 1'b1, 16'h0200, 16'd6},
    '{1'b1, 1'b1, 16'h0301, 16'd3}
  };

  initial begin
    logic [7:0]  r;
    logic [15:0] d, held_d, a, rem, n, wd, expd;
    vec_t v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    chk("R1 wr_ready", 32'(wr_ready), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    reg_rd(4'h8, r); chk("R1 addr lo", 32'(r), 32'd0);
    reg_rd(4'h9, r); chk("R1 addr hi", 32'(r), 32'd0);
    reg_rd(4'hA, r); chk("R1 cnt lo", 32'(r), 32'd0);
    reg_rd(4'h7, r); chk("R1 status", 32'(r), 32'd0);

    // table of transfers: R4 R6 R7 R8
    for (int i = 0; i < 6; i++) begin
      v = VECS[i];
      reg_wr(4'hE, {7'b0, v.word});
      reg_wr(4'h8, v.start[7:0]);
      reg_wr(4'h9, v.start[15:8]);
      reg_wr(4'hA, v.cnt[7:0]);
      reg_wr(4'hB, v.cnt[15:8]);
      reg_wr(4'h7, 8'h40);
      chk("R8 clear", 32'(done), 32'd0);
      reg_wr(4'h0, v.is_wr ? 8'h10 : 8'h08);
      a = v.start; rem = v.cnt;
      while (rem != 0) begin
        n = (v.word && rem >= 2) ? 16'd2 : 16'd1;
        if (!v.is_wr) begin
          wait_rd("R4 wait");
          held_d = rd_data;
          repeat (3) @(negedge clk);
          chk("R12 hold", 32'({rd_valid, rd_data}), 32'({1'b1, held_d}));
          pop("R4 wait", d);
          expd = (n == 2) ? {tbmem[10'(a + 1)], tbmem[a[9:0]]} : {8'h00, tbmem[a[9:0]]};
          chk("R4 data", 32'(d), 32'(expd));
        end else begin
          wd = 16'hC3A0 ^ (a * 16'h0105);
          push("R6 wait", wd);
          chk("R6 low lane", 32'(tbmem[a[9:0]]), 32'(wd[7:0]));
          if (n == 2) chk("R6 high lane", 32'(tbmem[10'(a + 1)]), 32'(wd[15:8]));
        end
        a = a + n; rem = rem - n;
      end
      chk("R8 done pin", 32'(done), 32'd1);
      reg_rd(4'h7, r); chk("R8 status", 32'(r), 32'h40);
      reg_rd(4'h8, r); chk("R7 end addr lo", 32'(r), 32'(a[7:0]));
      reg_rd(4'h9, r); chk("R7 end addr hi", 32'(r), 32'(a[15:8]));
      reg_rd(4'hA, r); chk("R7 end cnt", 32'(r), 32'd0);
      chk("R8 idle", 32'({rd_valid, wr_ready}), 32'd0);
      if (v.is_wr) chk("R6 past end", 32'(tbmem[a[9:0]]), 32'(initv(int'(a))));
    end

    // R5 prefetch readback, R12 hold, R10 abort
    reg_wr(4'hE, 8'h00);
    reg_wr(4'h8, 8'h20); reg_wr(4'h9, 8'h00);
    reg_wr(4'hA, 8'h03); reg_wr(4'hB, 8'h00);
    reg_wr(4'h7, 8'h40);
    reg_wr(4'h0, 8'h08);
    wait_rd("R5 wait");
    reg_rd(4'h8, r); chk("R5 ahead 1", 32'(r), 32'h21);
    pop("R5 wait", d);
    chk("R4 first byte", 32'(d), 32'(initv(32'h20)));
    @(negedge clk);
    wait_rd("R5 wait");
    reg_rd(4'h8, r); chk("R5 ahead 2", 32'(r), 32'h22);
    reg_rd(4'hA, r); chk("R7 count after one", 32'(r), 32'd2);
    reg_wr(4'h0, 8'h20);
    chk("R10 rd_valid", 32'(rd_valid), 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 stays idle", 32'({rd_valid, wr_ready}), 32'd0);
    reg_rd(4'hA, r); chk("R10 count frozen", 32'(r), 32'd2);
    reg_rd(4'h8, r); chk("R10 addr frozen", 32'(r), 32'h22);
    chk("R10 no done", 32'(done), 32'd0);

    // R11 idle data port traffic
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 16'hBEEF;
    repeat (4) @(negedge clk);
    chk("R11 wr_ready", 32'(wr_ready), 32'd0);
    wr_valid = 1'b0;
    chk("R11 mem", 32'(tbmem[10'h22]), 32'(initv(32'h22)));
    reg_rd(4'hA, r); chk("R11 count", 32'(r), 32'd2);
    reg_rd(4'h8, r); chk("R11 addr", 32'(r), 32'h22);

    // R9 zero count
    reg_wr(4'h8, 8'h50); reg_wr(4'h9, 8'h00);
    reg_wr(4'hA, 8'h00); reg_wr(4'hB, 8'h00);
    reg_wr(4'h0, 8'h10);
    chk("R9 done", 32'(done), 32'd1);
    chk("R9 wr_ready", 32'(wr_ready), 32'd0);
    wr_valid = 1'b1; wr_data = 16'h1234;
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    chk("R9 mem", 32'(tbmem[10'h50]), 32'(initv(32'h50)));

    // R2 no-op code, R12 ready without valid, R13 start rewrite
    reg_wr(4'h8, 8'h80); reg_wr(4'h9, 8'h01);
    reg_wr(4'hA, 8'h02); reg_wr(4'hB, 8'h00);
    reg_wr(4'h7, 8'h40);
    reg_wr(4'h0, 8'h10);
    reg_wr(4'h0, 8'h18);
    chk("R2 code 3 no effect", 32'(wr_ready), 32'd1);
    chk("R12 ready no valid", 32'(wr_ready && !wr_valid), 32'd1);
    reg_wr(4'h8, 8'h00); reg_wr(4'h9, 8'h00);
    push("R13 wait", 16'h0011);
    push("R13 wait", 16'h0022);
    chk("R13 byte 0", 32'(tbmem[10'h180]), 32'h11);
    chk("R13 byte 1", 32'(tbmem[10'h181]), 32'h22);
    chk("R13 new start untouched", 32'(tbmem[10'h000]), 32'(initv(0)));
    chk("R13 done", 32'(done), 32'd1);

    // R3 page gating and command readback
    reg_wr(4'h0, 8'h40);
    reg_rd(4'h8, r); chk("R3 page1 addr", 32'(r), 32'd0);
    reg_rd(4'h0, r); chk("R2 cmd readback", 32'(r), 32'h40);
    reg_wr(4'h0, 8'h00);
    reg_rd(4'h8, r); chk("R3 page0 addr", 32'(r), 32'h82);
    reg_rd(4'h9, r); chk("R3 page0 addr hi", 32'(r), 32'h01);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule